// File: doc/BRIEF.md
# Deterministic Quantum Controller with Region Ownership

This block makes the interleaving of NUM_THR hardware threads repeatable. Each thread gets a quantum of QUANTUM retired instructions per round. The controller keeps an ownership table with one entry per memory region. An entry records either a single owning thread or a shared state. Each cycle, every thread may present one memory request (valid, address, read/write) and a retire pulse. The controller answers each request with a combinational grant. A request that is not granted in a cycle is held by the thread.

A round begins in the parallel phase. Every thread runs at once, but only for accesses the table already allows. A thread's first access that is not allowed cuts its quantum. The thread then stalls until its turn in the serial phase. The serial phase gives turns to the cut threads one at a time, in ascending thread index. During its turn, a thread is granted every access and rewrites the ownership of the regions it touches. The turn ends when the thread has retired the rest of its quantum. After the last turn, one reload cycle restores all budgets and a new parallel phase starts.

The FSM has four states and these transitions:
- PARALLEL goes to SERIAL_PICK once every thread is cut or done.
- SERIAL_PICK goes to SERIAL_RUN while a cut thread remains, and to RELOAD when none is left.
- SERIAL_RUN goes back to SERIAL_PICK on the final retire of the thread whose turn it is.
- RELOAD goes to PARALLEL.

Top module: `qdet_ctrl`

## Requirements
- R1: After reset the block is in the parallel phase with every region shared, every budget full and no serial turn, so with no requests no grant is given.
- R2: In the parallel phase, a read by a running thread is granted only if the region is shared or owned by that thread.
- R3: In the parallel phase, a write by a running thread is granted only if the region is owned by that thread; a write to a shared region is refused.
- R4: A running thread's first refused access in the parallel phase cuts it. A cut thread gets no grant, and its retire pulses do not count, until its serial turn.
- R5: During a serial turn, a read of a region owned by a different thread makes that region shared.
- R6: During a serial turn, any write makes the region owned by the writing thread.
- R7: Budgets count only retire pulses from running threads: in the parallel phase, a thread that is neither cut nor done; in the serial phase, the thread whose turn it is. The retire that uses up QUANTUM ends the quantum, and the access presented in that same cycle is still granted.
- R8: The serial phase takes cut threads one at a time in ascending index. During a turn only that thread can be granted. The SERIAL_PICK cycle between turns grants nothing.
- R9: A thread that used up its quantum in the parallel phase gets no serial turn.
- R10: The serial phase starts in the cycle after the one in which every thread is first cut or done. After the last turn, one RELOAD cycle with no grants clears all flags and reloads all budgets before a new parallel phase.
- R11: The region index is the top REG_W bits of the address; the lower bits do not select the region.
- R12: The serial_mode output is 1 in SERIAL_PICK and SERIAL_RUN, and turn_valid is 1 only in SERIAL_RUN, with turn_tid naming the thread whose turn it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NUM_THR | Per-thread access request |
| req_write | input | NUM_THR | Per-thread 1 = write, 0 = read |
| req_addr | input | NUM_THR*ADDR_W | Per-thread address, thread t in bits [t*ADDR_W +: ADDR_W] |
| retire | input | NUM_THR | Per-thread instruction-retire pulse |
| req_grant | output | NUM_THR | Per-thread grant for the request in this cycle |
| serial_mode | output | 1 | 1 in SERIAL_PICK and SERIAL_RUN |
| turn_valid | output | 1 | 1 in SERIAL_RUN |
| turn_tid | output | TID_W | Thread whose turn it is during SERIAL_RUN |

## Verification
The bench opens with a round in which four threads do different things at once: a read of a shared region, a write to a shared region, and plain retiring. This shows the read rule and the write rule apart, and shows a cut thread apart from one that used up its quantum. The serial turns then replay the held writes and a read of another thread's region. A stray retire from a thread that was cut is counted only if the design is faulty, and then the turn ends early. The second round has mixed reads and writes of owned and shared regions. It shows that ownership changes from the serial turns stick and that budgets were reloaded. It also shows that the granted access in a thread's final retire cycle goes through, while later accesses do not.

// File: rtl/qdet_pkg.sv
package qdet_pkg;
    typedef enum logic [1:0] {
        ST_PARALLEL,
        ST_SERIAL_PICK,
        ST_SERIAL_RUN,
        ST_RELOAD
    } qdet_state_e;
endpackage

// File: rtl/qdet_own_table.sv
module qdet_own_table #(
    parameter int NUM_REG = 8,
    parameter int TID_W   = 2,
    parameter int REG_W   = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd_valid,
    input  logic             upd_write,
    input  logic [REG_W-1:0] upd_region,
    input  logic [TID_W-1:0] upd_tid,
    output logic [NUM_REG-1:0] rg_shared,
    output logic [TID_W-1:0]   rg_owner [NUM_REG]
);
    for (genvar r = 0; r < NUM_REG; r++) begin : g_entry
        logic hit;
        assign hit = upd_valid && (upd_region == REG_W'(r));
        always_ff @(posedge clk) begin
            if (rst) begin
                rg_shared[r] <= 1'b1;
                rg_owner[r]  <= '0;
            end else if (hit) begin
                if (upd_write) begin
                    rg_shared[r] <= 1'b0;
                    rg_owner[r]  <= upd_tid;
                end else if (!rg_shared[r] && rg_owner[r] != upd_tid) begin
                    rg_shared[r] <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/qdet_budget.sv
module qdet_budget #(
    parameter int QUANTUM = 4,
    parameter int CNT_W   = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic reload,
    input  logic count_en,
    output logic at_last
);
    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst || reload) begin
            remain <= CNT_W'(QUANTUM);
        end else if (count_en && remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign at_last = (remain == CNT_W'(1));
endmodule

// File: rtl/qdet_phase_fsm.sv
module qdet_phase_fsm
    import qdet_pkg::*;
#(
    parameter int NUM_THR = 4,
    parameter int TID_W   = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_THR-1:0] viol,
    input  logic [NUM_THR-1:0] last_ret,
    output qdet_state_e        state,
    output logic [NUM_THR-1:0] cut,
    output logic [NUM_THR-1:0] done,
    output logic [TID_W-1:0]   turn_tid,
    output logic               serial_mode,
    output logic               turn_valid,
    output logic               reload
);
    qdet_state_e      state_nx;
    logic [TID_W-1:0] pick_tid;

    always_comb begin
        pick_tid = '0;
        for (int t = NUM_THR - 1; t >= 0; t--) begin
            if (cut[t]) pick_tid = TID_W'(t);
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_PARALLEL:    if (&(cut | done)) state_nx = ST_SERIAL_PICK;
            ST_SERIAL_PICK: state_nx = (|cut) ? ST_SERIAL_RUN : ST_RELOAD;
            ST_SERIAL_RUN:  if (last_ret[turn_tid]) state_nx = ST_SERIAL_PICK;
            ST_RELOAD:      state_nx = ST_PARALLEL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_PARALLEL;
            turn_tid <= '0;
            cut      <= '0;
            done     <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_SERIAL_PICK) turn_tid <= pick_tid;
            if (state == ST_RELOAD) begin
                cut  <= '0;
                done <= '0;
            end else begin
                cut  <= (cut | viol) & ~last_ret;
                done <= done | last_ret;
            end
        end
    end

    always_comb begin
        serial_mode = 1'b0;
        turn_valid  = 1'b0;
        reload      = 1'b0;
        unique case (state)
            ST_PARALLEL:    ;
            ST_SERIAL_PICK: serial_mode = 1'b1;
            ST_SERIAL_RUN: begin
                serial_mode = 1'b1;
                turn_valid  = 1'b1;
            end
            ST_RELOAD:      reload = 1'b1;
        endcase
    end
endmodule

// File: rtl/qdet_ctrl.sv
module qdet_ctrl
    import qdet_pkg::*;
#(
    parameter int NUM_THR = 4,
    parameter int ADDR_W  = 16,
    parameter int REG_W   = 3,
    parameter int QUANTUM = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_THR-1:0]          req_valid,
    input  logic [NUM_THR-1:0]          req_write,
    input  logic [NUM_THR*ADDR_W-1:0]   req_addr,
    input  logic [NUM_THR-1:0]          retire,
    output logic [NUM_THR-1:0]          req_grant,
    output logic                        serial_mode,
    output logic                        turn_valid,
    output logic [$clog2(NUM_THR)-1:0]  turn_tid
);
    localparam int TID_W   = $clog2(NUM_THR);
    localparam int NUM_REG = 1 << REG_W;
    localparam int CNT_W   = $clog2(QUANTUM + 1);

    qdet_state_e        state;
    logic [NUM_THR-1:0] cut, done, viol, last_ret, at_last, running, permit;
    logic               reload;
    logic [NUM_REG-1:0] rg_shared;
    logic [TID_W-1:0]   rg_owner [NUM_REG];
    logic [REG_W-1:0]   rgn [NUM_THR];

    for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
        logic sh, mine;
        assign rgn[t] = req_addr[t*ADDR_W + ADDR_W - 1 -: REG_W];
        assign sh     = rg_shared[rgn[t]];
        assign mine   = !sh && (rg_owner[rgn[t]] == TID_W'(t));
        assign permit[t] = req_write[t] ? mine : (sh || mine);

        assign running[t] = ((state == ST_PARALLEL) && !cut[t] && !done[t])
                         || (turn_valid && turn_tid == TID_W'(t));
        assign req_grant[t] = req_valid[t] && running[t]
                           && (turn_valid || permit[t]);
        assign viol[t] = (state == ST_PARALLEL) && req_valid[t]
                      && running[t] && !permit[t];
        assign last_ret[t] = retire[t] && running[t] && at_last[t];

        qdet_budget #(.QUANTUM(QUANTUM), .CNT_W(CNT_W)) u_budget (
            .clk      (clk),
            .rst      (rst),
            .reload   (reload),
            .count_en (retire[t] && running[t]),
            .at_last  (at_last[t])
        );
    end

    qdet_phase_fsm #(.NUM_THR(NUM_THR), .TID_W(TID_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .viol        (viol),
        .last_ret    (last_ret),
        .state       (state),
        .cut         (cut),
        .done        (done),
        .turn_tid    (turn_tid),
        .serial_mode (serial_mode),
        .turn_valid  (turn_valid),
        .reload      (reload)
    );

    qdet_own_table #(.NUM_REG(NUM_REG), .TID_W(TID_W), .REG_W(REG_W)) u_table (
        .clk        (clk),
        .rst        (rst),
        .upd_valid  (turn_valid && req_valid[turn_tid]),
        .upd_write  (req_write[turn_tid]),
        .upd_region (rgn[turn_tid]),
        .upd_tid    (turn_tid),
        .rg_shared  (rg_shared),
        .rg_owner   (rg_owner)
    );
endmodule

// File: rtl/qdet_ctrl_chk.sv
module qdet_ctrl_chk #(
    parameter int NUM_THR = 4,
    parameter int ADDR_W  = 16,
    parameter int REG_W   = 3,
    parameter int TID_W   = 2,
    parameter int NUM_REG = 8
) (
    input logic                      clk,
    input logic                      rst,
    input logic [NUM_THR-1:0]        req_valid,
    input logic [NUM_THR-1:0]        req_write,
    input logic [NUM_THR*ADDR_W-1:0] req_addr,
    input logic [NUM_THR-1:0]        req_grant,
    input logic                      serial_mode,
    input logic                      turn_valid,
    input logic [TID_W-1:0]          turn_tid,
    input logic [NUM_REG-1:0]        rg_shared,
    input logic [TID_W-1:0]          rg_owner [NUM_REG]
);
    logic [REG_W-1:0] trg;
    logic [ADDR_W-1:0] taddr;
    assign taddr = req_addr[turn_tid*ADDR_W +: ADDR_W];
    assign trg   = taddr[ADDR_W-1 -: REG_W];

    for (genvar t = 0; t < NUM_THR; t++) begin : g_t
        logic [REG_W-1:0] r;
        assign r = req_addr[t*ADDR_W + ADDR_W - 1 -: REG_W];

        // R2
        a_r2_par_read: assert property (@(posedge clk) disable iff (rst)
            (!serial_mode && req_grant[t] && !req_write[t])
            |-> (rg_shared[r] || rg_owner[r] == TID_W'(t)));
        // R3
        a_r3_par_write: assert property (@(posedge clk) disable iff (rst)
            (!serial_mode && req_grant[t] && req_write[t])
            |-> (!rg_shared[r] && rg_owner[r] == TID_W'(t)));
    end

    // R8
    a_r8_one_turn: assert property (@(posedge clk) disable iff (rst)
        serial_mode |-> $onehot0(req_grant));
    a_r8_turn_only: assert property (@(posedge clk) disable iff (rst)
        (turn_valid && req_grant != '0) |-> req_grant[turn_tid]);
    a_r8_pick_quiet: assert property (@(posedge clk) disable iff (rst)
        (serial_mode && !turn_valid) |-> (req_grant == '0));
    // R12
    a_r12_turn_in_serial: assert property (@(posedge clk) disable iff (rst)
        turn_valid |-> serial_mode);
    // R6
    a_r6_serial_write: assert property (@(posedge clk) disable iff (rst)
        (turn_valid && req_valid[turn_tid] && req_write[turn_tid])
        |=> (!rg_shared[$past(trg)] && rg_owner[$past(trg)] == $past(turn_tid)));
    // R5
    a_r5_serial_read: assert property (@(posedge clk) disable iff (rst)
        (turn_valid && req_valid[turn_tid] && !req_write[turn_tid]
         && !rg_shared[trg] && rg_owner[trg] != turn_tid)
        |=> rg_shared[$past(trg)]);
endmodule

bind qdet_ctrl qdet_ctrl_chk #(
    .NUM_THR(NUM_THR), .ADDR_W(ADDR_W), .REG_W(REG_W),
    .TID_W($clog2(NUM_THR)), .NUM_REG(1 << REG_W)
) u_qdet_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_grant   (req_grant),
    .serial_mode (serial_mode),
    .turn_valid  (turn_valid),
    .turn_tid    (turn_tid),
    .rg_shared   (rg_shared),
    .rg_owner    (rg_owner)
);

// File: tb/test_qdet_ctrl.sv
module test_qdet_ctrl;
    localparam int N = 4;
    localparam int AW = 16;

    logic           clk = 1'b0;
    logic           rst;
    logic [N-1:0]   req_valid, req_write, retire;
    logic [N*AW-1:0] req_addr;
    logic [N-1:0]   req_grant;
    logic           serial_mode, turn_valid;
    logic [1:0]     turn_tid;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;   // 125 MHz

    qdet_ctrl #(.NUM_THR(N), .ADDR_W(AW), .REG_W(3), .QUANTUM(4)) i_qdet_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .retire(retire), .req_grant(req_grant),
        .serial_mode(serial_mode), .turn_valid(turn_valid), .turn_tid(turn_tid)
    );

    typedef struct {
        logic [N-1:0] g;
        bit           sm;
        bit           tv;
        logic [1:0]   tid;
        string        tag;
    } exp_t;
    exp_t sb[$];

    task automatic clr();
        req_valid = '0; req_write = '0; retire = '0; req_addr = '0;
    endtask

    // region in top 3 bits (R11); low bits vary per thread
    task automatic rq(int t, bit w, int r);
        req_valid[t] = 1'b1;
        req_write[t] = w;
        req_addr[t*AW +: AW] = {3'(r), 13'(t*97 + r*5 + 1)};
    endtask

    task automatic ex(logic [N-1:0] g, bit sm, bit tv, logic [1:0] tid, string tag);
        exp_t e;
        e.g = g; e.sm = sm; e.tv = tv; e.tid = tid; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (req_grant !== e.g || serial_mode !== e.sm || turn_valid !== e.tv
                    || (e.tv && turn_tid !== e.tid)) begin
                    errors++;
                    $display("FAIL %s: grant=%b sm=%b tv=%b tid=%0d expected grant=%b sm=%b tv=%b tid=%0d",
                             e.tag, req_grant, serial_mode, turn_valid, turn_tid,
                             e.g, e.sm, e.tv, e.tid);
                end
            end
        end
    end

    initial begin : watchdog
        #(8 * 20000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : driver
        rst = 1'b1; clr();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // c0: R1 reset state
        clr(); ex(4'b0000, 0, 0, 0, "R1 reset idle");
        // c1: R2 shared reads pass, R3 shared write refused (t0 cut), R11
        clr(); rq(0,1,1); rq(1,0,2); rq(2,0,3); rq(3,0,4);
        ex(4'b1110, 0, 0, 0, "R2 R3 R11 first parallel");
        // c2: t0 held (R4), t2 write shared refused
        clr(); rq(0,1,1); rq(2,1,3); retire = 4'b1010;
        ex(4'b0000, 0, 0, 0, "R3 R4 cut stays stalled");
        // c3
        clr(); rq(0,1,1); rq(2,1,3); rq(1,0,0); retire = 4'b1010;
        ex(4'b0010, 0, 0, 0, "R2 running read");
        // c4
        clr(); rq(0,1,1); rq(2,1,3); retire = 4'b1010;
        ex(4'b0000, 0, 0, 0, "R7 counting");
        // c5: t1,t3 finish; t0 retire while cut must be ignored (R4)
        clr(); rq(0,1,1); rq(2,1,3); retire = 4'b1011;
        ex(4'b0000, 0, 0, 0, "R7 quantum end");
        // c6: all cut/done, still parallel this cycle (R10)
        clr(); rq(0,1,1); rq(2,1,3);
        ex(4'b0000, 0, 0, 0, "R10 last parallel cycle");
        // c7: pick
        clr(); rq(0,1,1); rq(2,1,3);
        ex(4'b0000, 1, 0, 0, "R8 R12 pick grants nothing");
        // c8: t0 turn, write r1 (R6); t3 done request refused
        clr(); rq(0,1,1); rq(2,1,3); rq(3,0,1);
        ex(4'b0001, 1, 1, 0, "R6 R8 turn of t0");
        // c9
        clr(); rq(0,0,4); rq(2,1,3); retire = 4'b0001;
        ex(4'b0001, 1, 1, 0, "R8 t0 serial read");
        // c10..c12: t0 needs full 4 retires (R4: earlier retire ignored)
        clr(); rq(2,1,3); retire = 4'b0001;
        ex(4'b0000, 1, 1, 0, "R7 serial count");
        clr(); rq(2,1,3); retire = 4'b0001;
        ex(4'b0000, 1, 1, 0, "R7 serial count");
        clr(); rq(2,1,3); retire = 4'b0001;
        ex(4'b0000, 1, 1, 0, "R4 R7 t0 turn lasts full quantum");
        // c13: pick t2 (R9: t1 skipped)
        clr(); rq(2,1,3);
        ex(4'b0000, 1, 0, 0, "R8 pick next");
        // c14: t2 write r3
        clr(); rq(2,1,3);
        ex(4'b0100, 1, 1, 2, "R9 R8 turn of t2 ascending");
        // c15: t2 reads r1 owned by t0 -> shared (R5)
        clr(); rq(2,0,1); retire = 4'b0100;
        ex(4'b0100, 1, 1, 2, "R5 serial read of other owner");
        clr(); retire = 4'b0100; ex(4'b0000, 1, 1, 2, "R7 t2 count");
        clr(); retire = 4'b0100; ex(4'b0000, 1, 1, 2, "R7 t2 count");
        clr(); retire = 4'b0100; ex(4'b0000, 1, 1, 2, "R7 t2 last");
        // c19: pick finds none
        clr(); rq(1,0,2); ex(4'b0000, 1, 0, 0, "R10 pick none");
        // c20: reload
        clr(); rq(1,0,2); ex(4'b0000, 0, 0, 0, "R10 reload cycle");
        // c21: new round; r1 shared (R5), r3 owned by t2 (R6)
        clr(); rq(0,1,1); rq(1,0,1); rq(2,1,3); rq(3,0,3);
        ex(4'b0110, 0, 0, 0, "R2 R3 R5 R6 ownership after serial");
        // c22: t1 write shared refused; t2 reads own
        clr(); rq(0,1,1); rq(1,1,4); rq(2,0,3); retire = 4'b0100;
        ex(4'b0100, 0, 0, 0, "R3 R10 budgets reloaded");
        clr(); rq(2,0,3); retire = 4'b0100; ex(4'b0100, 0, 0, 0, "R7 t2 count");
        clr(); rq(2,0,3); retire = 4'b0100; ex(4'b0100, 0, 0, 0, "R7 t2 count");
        clr(); rq(2,0,3); retire = 4'b0100; ex(4'b0100, 0, 0, 0, "R7 last retire still granted");
        // c26: t2 done
        clr(); rq(2,0,3); ex(4'b0000, 0, 0, 0, "R7 done thread refused");
        // c27: pick, c28: t0 first
        clr(); rq(0,1,1); ex(4'b0000, 1, 0, 0, "R10 serial entered");
        clr(); rq(0,1,1); rq(1,1,4); ex(4'b0001, 1, 1, 0, "R8 lowest index first");
        #4;
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule